// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational 32-bit arithmetic and logic unit. It is built from identical one-bit slices chained through a ripple carry. Every slice receives two operand bits and an incoming carry. It may invert its A bit, invert its B bit, and then pick one of four values: the bitwise AND, the bitwise OR, the full-adder sum, or a "less" input. A four-bit control word selects the operation. Its bits, from bit 3 down to bit 0, are: invert-A, negate-B, and a two-bit slice select.

Subtraction inverts B and feeds the negate-B line into bit 0 as its carry-in. NAND and NOR are AND and OR of the inverted operands. Set-less-than performs A−B and routes the overflow-corrected sign from the top slice to the less input of slice 0. All other slices see a constant 0 on that input. An equality test uses the subtract code and reads the zero flag.

The flags are a zero indication, a signed overflow indication and the carry out of the top bit. The block has no clock. A caller places it between its operand and result registers.

Top module: `bitslice_alu`

## Requirements
- R1: Control 4'b0000 yields `a_in & b_in` and control 4'b0001 yields `a_in | b_in`.
- R2: Control 4'b0010 yields `a_in + b_in` modulo 2^32. `carry_out` is the unsigned carry out of bit 31. `overflow` is 1 exactly when the two operands share a sign bit and the result's sign bit differs from it.
- R3: Control 4'b0110 yields `a_in - b_in` modulo 2^32. `carry_out` is 1 exactly when `a_in >= b_in` as unsigned numbers. `overflow` is 1 exactly when the operand sign bits differ and the result's sign bit differs from that of `a_in`.
- R4: Control 4'b1100 yields `~(a_in | b_in)` and control 4'b1101 yields `~(a_in & b_in)`.
- R5: Control 4'b0111 yields 32'd1 when `a_in < b_in` as signed two's-complement numbers and 32'd0 otherwise. Bits 31..1 are always 0. The answer stays correct when A−B overflows.
- R6: `zero` is 1 exactly when all 32 result bits are 0, for every control code. Under control 4'b0110, `zero` is 1 exactly when `a_in == b_in`.
- R7: The codes 4'b0011, 4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1110 and 4'b1111 yield `a_in & b_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| ctrl | input | 4 | {invert-A, negate-B, select[1:0]} |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the adder |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
A broken carry link between two slices corrupts sums and differences only for operand pairs whose carry must travel across that link. For this reason the operand set includes 0, all ones, the most negative value, the most positive value and 1, so that long carry runs through every slice are exercised. A fault in the sign or overflow path of the top slice first appears as a wrong bit 0 under set-less-than. It shows most clearly with extreme operands whose difference overflows. Because there is no storage, every fault is visible within the same settle window as the input change. The bench therefore checks every operation against its model directly after the inputs are driven.

// File: rtl/alu_pkg.sv
// Package: control codes shared by the decoder, checker and documentation.
package alu_pkg;
    typedef enum logic [3:0] {
        CODE_AND  = 4'b0000,
        CODE_OR   = 4'b0001,
        CODE_ADD  = 4'b0010,
        CODE_SUB  = 4'b0110,
        CODE_SLT  = 4'b0111,
        CODE_NOR  = 4'b1100,
        CODE_NAND = 4'b1101
    } alu_code_e;

    localparam logic [1:0] SEL_AND  = 2'b00;
    localparam logic [1:0] SEL_OR   = 2'b01;
    localparam logic [1:0] SEL_SUM  = 2'b10;
    localparam logic [1:0] SEL_LESS = 2'b11;
endpackage

// File: rtl/alu_ctrl_decode.sv
// Control decoder: passes the seven defined codes through unchanged.
// Any other code is rewritten to the AND code.
// Assumes ctrl is stable for the whole evaluation window.
module alu_ctrl_decode
    import alu_pkg::*;
(
    input  logic [3:0] ctrl,
    output logic       inv_a,
    output logic       neg_b,
    output logic [1:0] sel
);
    logic [3:0] code_q;

    // Map undefined codes onto AND.
    always_comb begin
        case (ctrl)
            CODE_AND, CODE_OR, CODE_ADD, CODE_SUB,
            CODE_SLT, CODE_NOR, CODE_NAND: code_q = ctrl;
            default:                       code_q = CODE_AND;
        endcase
    end

    // Split the cleaned code into its slice control lines.
    always_comb begin
        inv_a = code_q[3];
        neg_b = code_q[2];
        sel   = code_q[1:0];
    end
endmodule

// File: rtl/alu_bit_slice.sv
// One lower ALU slice: conditionally inverts both operand bits, then picks
// AND, OR, full-adder sum or the less input. It also produces the ripple carry.
// Assumes the carry-in arrives from the slice below (or from negate-B at bit 0).
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       inv_a,
    input  logic       neg_b,
    input  logic       cin,
    input  logic       less,
    input  logic [1:0] sel,
    output logic       res,
    output logic       cout
);
    logic a_eff;
    logic b_eff;
    logic sum;

    // Operand conditioning and full adder.
    always_comb begin
        a_eff = a ^ inv_a;
        b_eff = b ^ neg_b;
        sum   = a_eff ^ b_eff ^ cin;
        cout  = (a_eff & b_eff) | (a_eff & cin) | (b_eff & cin);
    end

    // Output selection.
    always_comb begin
        case (sel)
            SEL_AND: res = a_eff & b_eff;
            SEL_OR:  res = a_eff | b_eff;
            SEL_SUM: res = sum;
            default: res = less;
        endcase
    end
endmodule

// File: rtl/alu_msb_slice.sv
// Top ALU slice: same datapath as a lower slice, plus the signed-overflow logic
// and the corrected sign that feeds set-less-than.
// Assumes its own less input is constant 0.
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       inv_a,
    input  logic       neg_b,
    input  logic       cin,
    input  logic [1:0] sel,
    output logic       res,
    output logic       cout,
    output logic       ovf,
    output logic       set_less
);
    logic a_eff;
    logic b_eff;
    logic sum;

    // Operand conditioning and full adder.
    always_comb begin
        a_eff = a ^ inv_a;
        b_eff = b ^ neg_b;
        sum   = a_eff ^ b_eff ^ cin;
        cout  = (a_eff & b_eff) | (a_eff & cin) | (b_eff & cin);
    end

    // Overflow from disagreeing carries; the true sign is the sum bit corrected by overflow.
    always_comb begin
        ovf      = cin ^ cout;
        set_less = sum ^ ovf;
    end

    // Output selection (the less input of this slice is tied to 0).
    always_comb begin
        case (sel)
            SEL_AND: res = a_eff & b_eff;
            SEL_OR:  res = a_eff | b_eff;
            SEL_SUM: res = sum;
            default: res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_zero_detect.sv
// Zero detector: reports when every result bit is low.
// Assumes W >= 1.
module alu_zero_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    output logic         is_zero
);
    // Wide NOR across the result.
    always_comb is_zero = ~(|value);
endmodule

// File: rtl/bitslice_alu.sv
// Bit-sliced ALU top: W-1 lower slices and one top slice on a ripple carry.
// The top slice returns its corrected sign to the less input of slice 0.
// Assumes W >= 2. Purely combinational.
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [3:0]   ctrl,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         overflow,
    output logic         carry_out
);
    localparam int TOP = W - 1;

    logic       inv_a;
    logic       neg_b;
    logic [1:0] sel;
    logic       carry   [W+1];
    logic       res_bit [W];
    logic       set_less;
    logic       ovf_w;

    alu_ctrl_decode u_dec (
        .ctrl  (ctrl),
        .inv_a (inv_a),
        .neg_b (neg_b),
        .sel   (sel)
    );

    // Negate-B doubles as the carry into bit 0.
    always_comb carry[0] = neg_b;

    for (genvar i = 0; i < W; i++) begin : g_slice
        if (i == TOP) begin : g_top
            alu_msb_slice u_msb (
                .a        (a_in[i]),
                .b        (b_in[i]),
                .inv_a    (inv_a),
                .neg_b    (neg_b),
                .cin      (carry[i]),
                .sel      (sel),
                .res      (res_bit[i]),
                .cout     (carry[i+1]),
                .ovf      (ovf_w),
                .set_less (set_less)
            );
        end else begin : g_low
            alu_bit_slice u_bit (
                .a     (a_in[i]),
                .b     (b_in[i]),
                .inv_a (inv_a),
                .neg_b (neg_b),
                .cin   (carry[i]),
                .less  ((i == 0) ? set_less : 1'b0),
                .sel   (sel),
                .res   (res_bit[i]),
                .cout  (carry[i+1])
            );
        end
    end

    // Gather the slice outputs into the result vector and drive the flags.
    always_comb begin
        for (int k = 0; k < W; k++) result[k] = res_bit[k];
        overflow  = ovf_w;
        carry_out = carry[W];
    end

    alu_zero_detect #(.W(W)) u_zero (
        .value   (result),
        .is_zero (zero)
    );
endmodule

// File: rtl/bitslice_alu_checker.sv
// Checker for bitslice_alu: immediate assertions on port behaviour.
// They are evaluated only once every input is known.
module bitslice_alu_checker
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [3:0]   ctrl,
    input logic [W-1:0] result,
    input logic         zero,
    input logic         overflow,
    input logic         carry_out
);
    logic known;

    // Flag when all inputs carry defined values.
    always_comb known = !$isunknown({a_in, b_in, ctrl});

    // Port-level properties.
    always_comb begin
        if (known) begin
            if (ctrl == CODE_AND)
                p_and_result_r1: assert (result == (a_in & b_in));
            if (ctrl == CODE_ADD)
                p_add_result_r2: assert ({carry_out, result} == ({1'b0, a_in} + {1'b0, b_in}));
            if (ctrl == CODE_SUB)
                p_sub_result_r3: assert (result == a_in - b_in);
            if (ctrl == CODE_NOR)
                p_nor_result_r4: assert (result == ~(a_in | b_in));
            if (ctrl == CODE_SLT)
                p_slt_value_r5: assert (result == (($signed(a_in) < $signed(b_in)) ? 1 : 0));
            p_zero_flag_r6: assert (zero == (result == '0));
            if (ctrl inside {4'b0011, 4'b0100, 4'b0101, 4'b1000, 4'b1001,
                             4'b1010, 4'b1011, 4'b1110, 4'b1111})
                p_unused_and_r7: assert (result == (a_in & b_in));
            if (ctrl == CODE_ADD)
                p_add_overflow_r2: assert (overflow ==
                    ((a_in[W-1] == b_in[W-1]) && (result[W-1] != a_in[W-1])));
        end
    end
endmodule

bind bitslice_alu bitslice_alu_checker #(.W(W)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .ctrl      (ctrl),
    .result    (result),
    .zero      (zero),
    .overflow  (overflow),
    .carry_out (carry_out)
);

// File: tb/tb_bitslice_alu.sv
// Bench for bitslice_alu: a behavioural model checks every control code over
// corner and random operands.
module tb_bitslice_alu;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [3:0]   ctrl = 4'b0000;
    logic [W-1:0] result;
    logic         zero;
    logic         overflow;
    logic         carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 100 MHz clock.
    always #5 clk = ~clk;

    bitslice_alu #(.W(W)) dut (
        .a_in      (a_in),
        .b_in      (b_in),
        .ctrl      (ctrl),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    // Requirement tag for each control code.
    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0000, 4'b0001: return "R1";
            4'b0010:          return "R2";
            4'b0110:          return "R3";
            4'b1100, 4'b1101: return "R4";
            4'b0111:          return "R5";
            default:          return "R7";
        endcase
    endfunction

    // Behavioural model of the result and flags.
    task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c,
                         output logic [W-1:0] r, output logic co, output logic ov);
        logic [W:0] wide;
        co = 1'b0;
        ov = 1'b0;
        case (c)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b0010: begin
                wide = {1'b0, a} + {1'b0, b};
                r  = wide[W-1:0];
                co = wide[W];
                ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'b0110: begin
                r  = a - b;
                co = (a >= b);
                ov = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'b1100: r = ~(a | b);
            4'b1101: r = ~(a & b);
            4'b0111: r = ($signed(a) < $signed(b)) ? 1 : 0;
            default: r = a & b;
        endcase
    endtask

    // Drive one operation, let it settle, then compare against the model.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
        logic [W-1:0] er;
        logic eco, eov, ez;
        @(negedge clk);
        a_in = a; b_in = b; ctrl = c;
        #2;
        model(a, b, c, er, eco, eov);
        ez = (er == '0);
        checks++;
        if (result !== er) begin
            fails++;
            $display("FAIL %s result ctrl=%b a=%h b=%h got=%h exp=%h", tag_of(c), c, a, b, result, er);
        end else if (zero !== ez) begin
            fails++;
            $display("FAIL R6 zero ctrl=%b a=%h b=%h got=%b exp=%b", c, a, b, zero, ez);
        end else if ((c == 4'b0010 || c == 4'b0110) && (carry_out !== eco || overflow !== eov)) begin
            fails++;
            $display("FAIL %s flags ctrl=%b a=%h b=%h got co=%b ov=%b exp co=%b ov=%b",
                     tag_of(c), c, a, b, carry_out, overflow, eco, eov);
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #1000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Main stimulus.
    initial begin
        logic [W-1:0] corners [5];
        corners[0] = '0;
        corners[1] = '1;
        corners[2] = {1'b1, {(W-1){1'b0}}};
        corners[3] = {1'b0, {(W-1){1'b1}}};
        corners[4] = 1;

        repeat (3) @(posedge clk);
        // Inputs all zero with the AND code: the result must be 0 and zero must be set (R6, R1).
        #2;
        checks++;
        if (result !== '0 || zero !== 1'b1) begin
            fails++;
            $display("FAIL R6 idle got=%h zero=%b exp=0 zero=1", result, zero);
        end
        rst_n = 1'b1;

        // Corner pairs under every code (R1-style coverage of each tag through tag_of).
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int c = 0; c < 16; c++)
                    apply(corners[i], corners[j], 4'(c));

        // Equality via subtract, R6: equal and unequal operands.
        apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
        apply(32'h1234_5678, 32'h1234_5679, 4'b0110);
        // R5 with overflowing difference: most negative less than a positive value.
        apply(32'h8000_0000, 32'h0000_0001, 4'b0111);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
        // R2 long carry run across every slice.
        apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);
        // R3 borrow run.
        apply(32'h0000_0000, 32'h0000_0001, 4'b0110);

        // Random operands under every code.
        for (int n = 0; n < 150; n++)
            for (int c = 0; c < 16; c++)
                apply($urandom, $urandom, 4'(c));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule